// File: doc/BRIEF.md
# Serial Nonlinear Round Engine (128-bit, 16 octets)

The block computes one 128-bit round of a byte-oriented block cipher from the SAFER+ family. It takes 16 input octets and two 16-octet round keys. The nonlinear key-mixing layer runs two octets per clock, so the whole datapath needs only one exponent table and one logarithm table. When the eight mixing steps are done, the block applies a fixed diffusion network. The network has four layers of pseudo-Hadamard transforms with an octet shuffle between adjacent layers. The result is registered and goes out with a one-cycle completion strobe.

A controller above the block drives `start` for one cycle with the state and both keys present. The block captures all three on that edge, so the caller may change the inputs afterwards. The result stays on `blk_out` until the next round completes. Key expansion, input feed-forward between rounds and the ordering of rounds are the caller's job.

Top module: `nl_round_core`

## Requirements
- R1: The exponent table gives e(x) = (45^x mod 257) mod 256 for x in 0..255. The value 256, reached at x = 128, is stored as 0.
- R2: The logarithm table is the inverse of e: l(e(x)) = x for every x in 0..255, so l(0) = 128.
- R3: Octet i of any 128-bit bus occupies bits [8i+7:8i]. For positions i with i mod 4 equal to 0 or 3, the mixed octet is e(x XOR a) + b mod 256. For all other positions it is l(x + a mod 256) XOR b. Here x is the state octet, a is octet i of `key_a` and b is octet i of `key_b`.
- R4: A pseudo-Hadamard step on the octet pair (2p, 2p+1) with values (u, v) produces (2u + v mod 256, u + v mod 256), for p = 0..7.
- R5: The diffusion network applies four pseudo-Hadamard layers to the mixed state. Between consecutive layers, output octet j takes input octet P[j], where P = 8, 11, 12, 15, 2, 1, 6, 5, 10, 9, 14, 13, 0, 7, 4, 3.
- R6: Assume `start` is sampled high at a rising edge while the block is idle. `done` then stays low for the next 8 rising edges and is high after the 9th. `blk_out` carries the R3–R5 result in that same cycle.
- R7: `done` is high for exactly one clock cycle per round.
- R8: `blk_out` changes only in a cycle in which `done` is high. Otherwise it holds its value, whatever the inputs do.
- R9: All three data inputs are captured at the accepted `start`. Later changes to them, and any `start` pulse sampled before the round's `done` cycle, have no effect on the result or its timing.
- R10: While `rst` is high, and in the first cycle after it is released, `done` is 0 and `blk_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a round when the block is idle |
| blk_in | input | 128 | Round input state, 16 octets |
| key_a | input | 128 | First round key (XOR / add before the tables) |
| key_b | input | 128 | Second round key (add / XOR after the tables) |
| blk_out | output | 128 | Registered round result |
| done | output | 1 | One-cycle strobe marking a new result |

## Verification
The in-line properties check the controller on every cycle. They confirm that `done` is a single-cycle strobe issued only from the final state, that the step sequence advances by one each cycle whatever `start` does, and that `blk_out` holds between strobes. The arithmetic cannot be checked that way, so the bench does it. It sweeps all 256 octet values through both tables with zero keys and again with key-only variation, then compares random rounds against a model built from the table definitions, the pairing rule and the shuffle order. The timing scenarios show that late `start` pulses and input changes are ignored: a round is disturbed mid-flight and the bench checks the result stays unchanged.

// File: rtl/nl_round_pkg.sv
package nl_round_pkg;
  localparam int OCT_W    = 8;
  localparam int N_OCT    = 16;
  localparam int N_LEVELS = 4;

  // Source octet for destination j of the inter-layer shuffle.
  function automatic int perm_src(input int j);
    case (j)
      0: return 8;   1: return 11;  2: return 12;  3: return 15;
      4: return 2;   5: return 1;   6: return 6;   7: return 5;
      8: return 10;  9: return 9;   10: return 14; 11: return 13;
      12: return 0;  13: return 7;  14: return 4;  default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/pow_log_rom.sv
module pow_log_rom #(
  parameter int OW    = 8,
  parameter int BASE  = 45,
  parameter int MODP  = 257
) (
  input  logic [OW-1:0] exp_addr,
  input  logic [OW-1:0] log_addr,
  output logic [OW-1:0] exp_data,
  output logic [OW-1:0] log_data
);
  localparam int DEPTH = 1 << OW;

  logic [OW-1:0] exp_mem [DEPTH];
  logic [OW-1:0] log_mem [DEPTH];

  // Tables filled by running the power sequence once; the log table is
  // written as the inverse image of each exponent entry.
  initial begin
    int unsigned acc;
    acc = 1;
    for (int i = 0; i < DEPTH; i++) begin
      exp_mem[i] = OW'(acc);
      log_mem[OW'(acc)] = OW'(i);
      acc = (acc * BASE) % MODP;
    end
  end

  assign exp_data = exp_mem[exp_addr];
  assign log_data = log_mem[log_addr];
endmodule

// File: rtl/pair_mixer.sv
module pair_mixer #(
  parameter int OW = 8
) (
  input  logic          swap,      // high on odd slices: exp path serves the upper octet
  input  logic [OW-1:0] lo_x,
  input  logic [OW-1:0] hi_x,
  input  logic [OW-1:0] lo_ka,
  input  logic [OW-1:0] hi_ka,
  input  logic [OW-1:0] lo_kb,
  input  logic [OW-1:0] hi_kb,
  output logic [OW-1:0] exp_addr,
  output logic [OW-1:0] log_addr,
  input  logic [OW-1:0] exp_data,
  input  logic [OW-1:0] log_data,
  output logic [OW-1:0] lo_y,
  output logic [OW-1:0] hi_y
);
  always_comb begin
    if (!swap) begin
      exp_addr = lo_x ^ lo_ka;
      log_addr = hi_x + hi_ka;
      lo_y     = exp_data + lo_kb;
      hi_y     = log_data ^ hi_kb;
    end else begin
      exp_addr = hi_x ^ hi_ka;
      log_addr = lo_x + lo_ka;
      lo_y     = log_data ^ lo_kb;
      hi_y     = exp_data + hi_kb;
    end
  end
endmodule

// File: rtl/pht_net.sv
module pht_net #(
  parameter int OW     = nl_round_pkg::OCT_W,
  parameter int NOCT   = nl_round_pkg::N_OCT,
  parameter int LEVELS = nl_round_pkg::N_LEVELS
) (
  input  logic [NOCT-1:0][OW-1:0] din,
  output logic [NOCT-1:0][OW-1:0] dout
);
  localparam int PAIRS = NOCT / 2;

  logic [OW-1:0] lv_in  [LEVELS][NOCT];
  logic [OW-1:0] lv_pht [LEVELS][NOCT];

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    for (genvar j = 0; j < NOCT; j++) begin : g_src
      if (lv == 0) begin : g_first
        assign lv_in[lv][j] = din[j];
      end else begin : g_shuf
        assign lv_in[lv][j] = lv_pht[lv-1][nl_round_pkg::perm_src(j)];
      end
    end
    for (genvar p = 0; p < PAIRS; p++) begin : g_pht
      assign lv_pht[lv][2*p]   = {lv_in[lv][2*p][OW-2:0], 1'b0} + lv_in[lv][2*p+1];
      assign lv_pht[lv][2*p+1] = lv_in[lv][2*p] + lv_in[lv][2*p+1];
    end
  end

  for (genvar j = 0; j < NOCT; j++) begin : g_out
    assign dout[j] = lv_pht[LEVELS-1][j];
  end
endmodule

// File: rtl/nl_round_core.sv
module nl_round_core #(
  parameter int OW   = nl_round_pkg::OCT_W,
  parameter int NOCT = nl_round_pkg::N_OCT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [NOCT*OW-1:0] blk_in,
  input  logic [NOCT*OW-1:0] key_a,
  input  logic [NOCT*OW-1:0] key_b,
  output logic [NOCT*OW-1:0] blk_out,
  output logic               done
);
  localparam int PAIRS = NOCT / 2;
  localparam int PHW   = $clog2(PAIRS + 2);
  localparam int PIW   = $clog2(PAIRS);
  localparam logic [PHW-1:0] PH_IDLE = '0;
  localparam logic [PHW-1:0] PH_END  = PHW'(PAIRS + 1);

  // Phase: 0 idle, 1..PAIRS mixing slices, PAIRS+1 final (10 states at defaults).
  logic [PHW-1:0]          phase_q;
  logic [NOCT-1:0][OW-1:0] st_q, ka_q, kb_q, diff_out;
  logic [PIW-1:0]          pidx;
  logic [OW-1:0]           e_addr, l_addr, e_data, l_data, y_lo, y_hi;

  assign pidx = PIW'(phase_q - 1'b1);

  pow_log_rom #(.OW(OW)) u_rom (
    .exp_addr(e_addr), .log_addr(l_addr),
    .exp_data(e_data), .log_data(l_data)
  );

  pair_mixer #(.OW(OW)) u_mix (
    .swap(pidx[0]),
    .lo_x(st_q[2*pidx]),  .hi_x(st_q[2*pidx+1]),
    .lo_ka(ka_q[2*pidx]), .hi_ka(ka_q[2*pidx+1]),
    .lo_kb(kb_q[2*pidx]), .hi_kb(kb_q[2*pidx+1]),
    .exp_addr(e_addr), .log_addr(l_addr),
    .exp_data(e_data), .log_data(l_data),
    .lo_y(y_lo), .hi_y(y_hi)
  );

  pht_net #(.OW(OW), .NOCT(NOCT)) u_pht (
    .din(st_q), .dout(diff_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      st_q    <= '0;
      ka_q    <= '0;
      kb_q    <= '0;
      blk_out <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (start) begin
          st_q    <= blk_in;
          ka_q    <= key_a;
          kb_q    <= key_b;
          phase_q <= phase_q + 1'b1;
        end
      end else if (phase_q == PH_END) begin
        blk_out <= diff_out;
        done    <= 1'b1;
        phase_q <= PH_IDLE;
      end else begin
        st_q[2*pidx]   <= y_lo;
        st_q[2*pidx+1] <= y_hi;
        phase_q        <= phase_q + 1'b1;
      end
    end
  end

  // R7: completion strobe lasts a single cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: strobe only follows the final state
  p_done_from_end_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(phase_q) == PH_END);

  // R8: result holds between strobes
  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(blk_out));

  // R9: once busy, the sequence advances every cycle regardless of start
  p_busy_advance_r9: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_IDLE && phase_q != PH_END) |=> phase_q == $past(phase_q) + 1'b1);

  // R9: final state always returns to idle
  p_end_to_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_END) |=> phase_q == PH_IDLE);
endmodule

// File: tb/tb_nl_round_core.sv
`timescale 1ns/1ps
module tb_nl_round_core;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] blk_in = '0, key_a = '0, key_b = '0;
  logic [127:0] blk_out;
  logic         done;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_t [256];
  logic [7:0] log_t [256];
  int perm_t [16] = '{8, 11, 12, 15, 2, 1, 6, 5, 10, 9, 14, 13, 0, 7, 4, 3};
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  nl_round_core dut (
    .clk(clk), .rst(rst), .start(start), .blk_in(blk_in),
    .key_a(key_a), .key_b(key_b), .blk_out(blk_out), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  function automatic logic [127:0] rnd128();
    return {rnd(), rnd(), rnd(), rnd()};
  endfunction

  // Model: R1/R2 tables, R3 mixing, R4 pht, R5 shuffle.
  function automatic logic [127:0] ref_round(input logic [127:0] x, input logic [127:0] ka, input logic [127:0] kb);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] u, v;
    logic [127:0] r;
    for (int i = 0; i < 16; i++) begin
      if (i % 4 == 0 || i % 4 == 3)
        s[i] = exp_t[x[8*i +: 8] ^ ka[8*i +: 8]] + kb[8*i +: 8];
      else
        s[i] = log_t[8'(x[8*i +: 8] + ka[8*i +: 8])] ^ kb[8*i +: 8];
    end
    for (int lv = 0; lv < 4; lv++) begin
      for (int p = 0; p < 8; p++) begin
        u = s[2*p]; v = s[2*p+1];
        s[2*p]   = 8'(2*u + v);
        s[2*p+1] = u + v;
      end
      if (lv < 3) begin
        for (int j = 0; j < 16; j++) t[j] = s[j];
        for (int j = 0; j < 16; j++) s[j] = t[perm_t[j]];
      end
    end
    for (int i = 0; i < 16; i++) r[8*i +: 8] = s[i];
    return r;
  endfunction

  // One round; poke > 0 pulses start with junk data at that cycle (R9).
  task automatic run_round(input logic [127:0] x, input logic [127:0] ka, input logic [127:0] kb,
                           input int poke, input string req);
    logic [127:0] want;
    bit early;
    want = ref_round(x, ka, kb);
    early = 1'b0;
    @(negedge clk);
    start = 1'b1; blk_in = x; key_a = ka; key_b = kb;
    @(negedge clk);                       // edge E0 has sampled start
    start = 1'b0; blk_in = ~x; key_a = rnd128(); key_b = rnd128();
    for (int c = 1; c <= 8; c++) begin
      if (c == poke) begin
        start = 1'b1; blk_in = rnd128();
      end
      @(negedge clk);                     // now after edge Ec
      start = 1'b0;
      if (done) early = 1'b1;
    end
    check(!early, {req, " R6 done early"}, 128'(early), 128'd0);
    @(negedge clk);                       // after E9
    check(done == 1'b1, {req, " R6 done at 9th edge"}, 128'(done), 128'd1);
    check(blk_out == want, {req, " R3/R4/R5 result"}, blk_out, want);
    @(negedge clk);                       // after E10
    check(done == 1'b0, {req, " R7 single-cycle done"}, 128'(done), 128'd0);
    check(blk_out == want, {req, " R8 result held"}, blk_out, want);
  endtask

  initial begin
    logic [127:0] held, rep;
    int unsigned acc;
    acc = 1;
    for (int i = 0; i < 256; i++) begin
      exp_t[i] = 8'(acc);
      log_t[8'(acc)] = 8'(i);
      acc = (acc * 45) % 257;
    end
    // R1/R2 spot values in the model itself
    check(exp_t[128] == 8'd0 && log_t[0] == 8'd128, "R1 R2 model", 128'(exp_t[128]), 128'd0);

    repeat (3) @(negedge clk);
    check(done == 1'b0 && blk_out == '0, "R10 in reset", blk_out, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && blk_out == '0, "R10 after release", blk_out, 128'd0);

    // R1/R2/R3: every octet value through both tables, zero keys
    for (int v = 0; v < 256; v++) begin
      rep = {16{8'(v)}};
      run_round(rep, '0, '0, 0, "R1 R2 sweep");
    end
    // R3: key paths swept, fixed state
    for (int v = 0; v < 256; v++) begin
      rep = {16{8'(v)}};
      run_round(128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, rep, ~rep, 0, "R3 key sweep");
    end
    // R4/R5: random rounds
    for (int n = 0; n < 120; n++) run_round(rnd128(), rnd128(), rnd128(), 0, "R5 random");
    // R9: start pulses while busy at every step position
    for (int c = 1; c <= 8; c++) run_round(rnd128(), rnd128(), rnd128(), c, "R9 busy start");

    // R8: no start, inputs wander, output must not move
    held = blk_out;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      blk_in = rnd128(); key_a = rnd128(); key_b = rnd128();
      check(blk_out == held && !done, "R8 idle hold", blk_out, held);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule